// File: doc/BRIEF.md
# Least-Weight Output Selector

This block is the arbiter that sits at one input of a crossbar with a small buffer at every crosspoint. In every slot it looks at the outputs this input may send to and picks the one whose crosspoint column is least full. An output may be sent to when this input holds a cell for it and the crosspoint buffer of that pair still has room. The fullness of each column is given as a weight: the total number of cells held in all crosspoint buffers feeding that output.

The input makes its choice alone, with no knowledge of what the other inputs pick in the same slot. A balanced tree of two-way comparators finds the minimum, so the path from inputs to result grows with log2 of the output count. The result is available combinationally in the same cycle. A registered copy of the choice is taken once per slot, on a slot strobe.

Updating the column weights and any coordination between inputs are left to the surrounding logic.

Top module: `lwsel_top`

## Requirements
- R1: When `pick_valid` is 1, bit `pick_idx` of `elig` is 1, so an output that is not eligible is never chosen.
- R2: When `pick_valid` is 1, `pick_weight` equals the weight of output `pick_idx`, and no eligible output has a smaller weight.
- R3: When several eligible outputs share the smallest weight, the one with the lowest index is chosen.
- R4: When `elig` is all zero, `pick_valid` is 0 and `pick_idx` is 0. When any bit of `elig` is set, `pick_valid` is 1.
- R5: The weight of an output whose `elig` bit is 0 has no effect on the result, even when that weight is 0.
- R6: An eligible output with the largest weight code (all ones) is still chosen when it is the only eligible output.
- R7: The `pick_*` outputs follow `elig` and `weights` in the same cycle, with no register on the path.
- R8: On a rising clock edge with `slot_tick` high, `grant_valid` and `grant_idx` take the values of `pick_valid` and `pick_idx`. On an edge with `slot_tick` low, they keep their values.
- R9: While `rst_n` is low, `grant_valid` and `grant_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| slot_tick | input | 1 | Slot strobe; the registered grant is loaded on an edge where this is high |
| elig | input | N_OUT | Bit j is 1 when output j may be chosen this slot |
| weights | input | N_OUT*WW | Column occupancy of output j in bits [j*WW +: WW]; WW = clog2(N_OUT*CAP+1) |
| pick_valid | output | 1 | Combinational: at least one output is eligible |
| pick_idx | output | IW | Combinational: chosen output index; IW = clog2(N_OUT) |
| pick_weight | output | WW | Combinational: weight of the chosen output (all ones when none is chosen) |
| grant_valid | output | 1 | Registered `pick_valid`, loaded per slot |
| grant_idx | output | IW | Registered `pick_idx`, loaded per slot |

## Verification
The `pick_*` results have zero latency. The bench therefore drives `elig` and `weights` just after a falling edge and samples a few nanoseconds later, before the next rising edge. The grant pair is due one rising edge after a cycle in which `slot_tick` is high. The bench raises the strobe at a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. To check that the grant holds, it changes the inputs with the strobe low across two rising edges and confirms that the grant still shows the older choice while the combinational pick already shows the new one.

// File: rtl/lwsel_pkg.sv
package lwsel_pkg;

  // Number of bits needed to hold a column occupancy of 0 .. n_out*cap.
  function automatic int weight_bits(input int n_out, input int cap);
    return $clog2(n_out * cap + 1);
  endfunction

  // Comparator decision for one tree node. The left operand always carries
  // the lower output indices, so a tie goes left (lowest index wins).
  function automatic logic left_wins(input logic lv, input logic rv,
                                     input int unsigned lw,
                                     input int unsigned rw);
    return lv && (!rv || (lw <= rw));
  endfunction

endpackage

// File: rtl/lwsel_leaf.sv
module lwsel_leaf #(
  parameter int WW  = 7,
  parameter int IW  = 3,
  parameter int IDX = 0
) (
  input  logic          en,
  input  logic [WW-1:0] w_in,
  output logic          v_out,
  output logic [WW-1:0] w_out,
  output logic [IW-1:0] i_out
);
  // An output that may not be chosen carries the largest weight code and no
  // valid flag, so it can only win against other invalid leaves.
  assign v_out = en;
  assign w_out = en ? w_in : {WW{1'b1}};
  assign i_out = IW'(IDX);
endmodule

// File: rtl/lwsel_merge.sv
module lwsel_merge
  import lwsel_pkg::*;
#(
  parameter int WW = 7,
  parameter int IW = 3
) (
  input  logic          a_v,
  input  logic [WW-1:0] a_w,
  input  logic [IW-1:0] a_i,
  input  logic          b_v,
  input  logic [WW-1:0] b_w,
  input  logic [IW-1:0] b_i,
  output logic          o_v,
  output logic [WW-1:0] o_w,
  output logic [IW-1:0] o_i
);
  logic take_a;

  assign take_a = left_wins(a_v, b_v, 32'(a_w), 32'(b_w));
  assign o_v    = a_v | b_v;
  assign o_w    = take_a ? a_w : (b_v ? b_w : {WW{1'b1}});
  assign o_i    = take_a ? a_i : (b_v ? b_i : {IW{1'b0}});
endmodule

// File: rtl/lwsel_tree.sv
module lwsel_tree #(
  parameter int N_OUT = 8,
  parameter int WW    = 7,
  localparam int IW     = $clog2(N_OUT),
  localparam int LEVELS = $clog2(N_OUT)
) (
  input  logic [N_OUT-1:0]    elig,
  input  logic [N_OUT*WW-1:0] weights,
  output logic                top_v,
  output logic [WW-1:0]       top_w,
  output logic [IW-1:0]       top_i
);
  // Node storage per level; level 0 holds the leaves, level LEVELS the root.
  logic          nv [LEVELS+1][N_OUT];
  logic [WW-1:0] nw [LEVELS+1][N_OUT];
  logic [IW-1:0] ni [LEVELS+1][N_OUT];

  for (genvar j = 0; j < N_OUT; j++) begin : g_leaf
    lwsel_leaf #(.WW(WW), .IW(IW), .IDX(j)) u_leaf (
      .en   (elig[j]),
      .w_in (weights[j*WW +: WW]),
      .v_out(nv[0][j]),
      .w_out(nw[0][j]),
      .i_out(ni[0][j])
    );
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int NODES = N_OUT >> l;
    for (genvar k = 0; k < NODES; k++) begin : g_node
      lwsel_merge #(.WW(WW), .IW(IW)) u_merge (
        .a_v(nv[l-1][2*k]),   .a_w(nw[l-1][2*k]),   .a_i(ni[l-1][2*k]),
        .b_v(nv[l-1][2*k+1]), .b_w(nw[l-1][2*k+1]), .b_i(ni[l-1][2*k+1]),
        .o_v(nv[l][k]),       .o_w(nw[l][k]),       .o_i(ni[l][k])
      );
    end
    for (genvar k = NODES; k < N_OUT; k++) begin : g_unused
      assign nv[l][k] = 1'b0;
      assign nw[l][k] = {WW{1'b1}};
      assign ni[l][k] = {IW{1'b0}};
    end
  end

  assign top_v = nv[LEVELS][0];
  assign top_w = nw[LEVELS][0];
  assign top_i = ni[LEVELS][0];
endmodule

// File: rtl/lwsel_top.sv
module lwsel_top
  import lwsel_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int CAP   = 8,
  localparam int WW = weight_bits(N_OUT, CAP),
  localparam int IW = $clog2(N_OUT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_tick,
  input  logic [N_OUT-1:0]    elig,
  input  logic [N_OUT*WW-1:0] weights,
  output logic                pick_valid,
  output logic [IW-1:0]       pick_idx,
  output logic [WW-1:0]       pick_weight,
  output logic                grant_valid,
  output logic [IW-1:0]       grant_idx
);
  // Named result of the comparison tree, brought out for the checker.
  logic          tree_v;
  logic [WW-1:0] tree_w;
  logic [IW-1:0] tree_i;
  logic          grant_load;

  lwsel_tree #(.N_OUT(N_OUT), .WW(WW)) u_tree (
    .elig   (elig),
    .weights(weights),
    .top_v  (tree_v),
    .top_w  (tree_w),
    .top_i  (tree_i)
  );

  assign pick_valid  = tree_v;
  assign pick_idx    = tree_i;
  assign pick_weight = tree_w;
  assign grant_load  = slot_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
    end else if (grant_load) begin
      grant_valid <= tree_v;
      grant_idx   <= tree_i;
    end
  end
endmodule

// File: rtl/lwsel_chk.sv
module lwsel_chk #(
  parameter int N_OUT = 8,
  parameter int WW    = 7,
  parameter int IW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_tick,
  input logic [N_OUT-1:0]    elig,
  input logic [N_OUT*WW-1:0] weights,
  input logic                pick_valid,
  input logic [IW-1:0]       pick_idx,
  input logic [WW-1:0]       pick_weight,
  input logic                grant_valid,
  input logic [IW-1:0]       grant_idx
);
  assert_pick_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> elig[pick_idx]);

  assert_pick_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (pick_weight == weights[pick_idx*WW +: WW]));

  assert_valid_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid == (elig != '0));

  assert_none_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> (pick_idx == '0));

  for (genvar j = 0; j < N_OUT; j++) begin : g_per_out
    assert_no_smaller_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && elig[j]) |-> (pick_weight <= weights[j*WW +: WW]));

    assert_tie_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && elig[j] && (weights[j*WW +: WW] == pick_weight))
        |-> (pick_idx <= IW'(j)));
  end

  assert_grant_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> (grant_valid == $past(pick_valid)) && (grant_idx == $past(pick_idx)));

  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(grant_valid) && $stable(grant_idx));

  assert_reset_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!grant_valid && grant_idx == '0));
endmodule

bind lwsel_top lwsel_chk #(.N_OUT(N_OUT), .WW(WW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_tick  (slot_tick),
  .elig       (elig),
  .weights    (weights),
  .pick_valid (pick_valid),
  .pick_idx   (pick_idx),
  .pick_weight(pick_weight),
  .grant_valid(grant_valid),
  .grant_idx  (grant_idx)
);

// File: tb/sim_lwsel_top.sv
`timescale 1ns/1ps
module sim_lwsel_top;
  localparam int N   = 8;
  localparam int CAP = 8;
  localparam int WW  = $clog2(N*CAP+1);
  localparam int IW  = $clog2(N);
  localparam logic [WW-1:0] WMAX = {WW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_tick = 1'b0;
  logic [N-1:0]  elig = '0;
  logic [N*WW-1:0] weights = '0;
  logic          pick_valid;
  logic [IW-1:0] pick_idx;
  logic [WW-1:0] pick_weight;
  logic          grant_valid;
  logic [IW-1:0] grant_idx;

  logic [WW-1:0] wv [N];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lwsel_top #(.N_OUT(N), .CAP(CAP)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .elig(elig),
    .weights(weights), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .pick_weight(pick_weight), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // Independent reference: scan outputs from index 0 upward, keep a strictly
  // smaller weight only, so the earliest of equal minima stays.
  task automatic ref_pick(output bit v, output int idx, output int w);
    v = 1'b0; idx = 0; w = int'(WMAX);
    for (int j = 0; j < N; j++) begin
      if (elig[j] && (!v || int'(wv[j]) < w)) begin
        v = 1'b1; idx = j; w = int'(wv[j]);
      end
    end
  endtask

  task automatic apply(input logic [N-1:0] e);
    @(negedge clk);
    elig = e;
    for (int j = 0; j < N; j++) weights[j*WW +: WW] = wv[j];
    #2;
  endtask

  task automatic check_pick(input string req);
    bit v; int idx; int w;
    ref_pick(v, idx, w);
    check(req, "pick_valid", int'(pick_valid), int'(v));
    check(req, "pick_idx", int'(pick_idx), idx);
    if (v) check(req, "pick_weight", int'(pick_weight), w);
  endtask

  task automatic t_reset;
    check("R9", "grant_valid in reset", int'(grant_valid), 0);
    check("R9", "grant_idx in reset", int'(grant_idx), 0);
  endtask

  task automatic t_distinct;  // R1 R2 R7: all eligible, distinct weights
    for (int j = 0; j < N; j++) wv[j] = WW'(40 - 3*j);
    wv[5] = 7'd2;
    apply(8'hFF); check_pick("R2");
    check("R2", "min at 5", int'(pick_idx), 5);
    apply(8'b1101_1111); check_pick("R1");  // output 5 no longer eligible
    check("R1", "skip ineligible min", int'(pick_idx), 7);
    check("R7", "same-cycle weight", int'(pick_weight), 19);
  endtask

  task automatic t_single;  // R1 R6
    for (int j = 0; j < N; j++) wv[j] = 7'd0;
    wv[3] = WMAX;
    apply(8'b0000_1000); check_pick("R6");
    check("R6", "all-ones weight chosen", int'(pick_idx), 3);
    check("R6", "valid with all-ones", int'(pick_valid), 1);
  endtask

  task automatic t_ties;  // R3
    for (int j = 0; j < N; j++) wv[j] = 7'd9;
    wv[2] = 7'd4; wv[6] = 7'd4; wv[7] = 7'd4;
    apply(8'hFF); check_pick("R3");
    check("R3", "lowest of ties", int'(pick_idx), 2);
    apply(8'b1100_0000); check_pick("R3");
    check("R3", "tie across subtree", int'(pick_idx), 6);
    for (int j = 0; j < N; j++) wv[j] = 7'd17;
    apply(8'b1010_0100); check_pick("R3");
    check("R3", "all equal", int'(pick_idx), 2);
  endtask

  task automatic t_none;  // R4
    for (int j = 0; j < N; j++) wv[j] = WW'(j);
    apply(8'h00);
    check("R4", "none valid", int'(pick_valid), 0);
    check("R4", "none idx", int'(pick_idx), 0);
    apply(8'b1000_0000);
    check("R4", "one bit valid", int'(pick_valid), 1);
  endtask

  task automatic t_masked;  // R5
    for (int j = 0; j < N; j++) wv[j] = 7'd0;
    wv[1] = 7'd50; wv[4] = 7'd33;
    apply(8'b0001_0010); check_pick("R5");
    check("R5", "zero-weight ineligible ignored", int'(pick_idx), 4);
    check("R5", "weight of pick", int'(pick_weight), 33);
  endtask

  task automatic t_grant;  // R8
    for (int j = 0; j < N; j++) wv[j] = 7'd30;
    wv[6] = 7'd1;
    apply(8'hFF);
    slot_tick = 1'b1;
    @(negedge clk); slot_tick = 1'b0; #2;
    check("R8", "grant loaded idx", int'(grant_idx), 6);
    check("R8", "grant loaded valid", int'(grant_valid), 1);
    wv[0] = 7'd0;
    apply(8'hFF);
    @(negedge clk); #2;
    check("R8", "grant held idx", int'(grant_idx), 6);
    check("R7", "pick moved", int'(pick_idx), 0);
    apply(8'h00);
    slot_tick = 1'b1;
    @(negedge clk); slot_tick = 1'b0; #2;
    check("R8", "grant loaded empty", int'(grant_valid), 0);
    check("R8", "grant idx empty", int'(grant_idx), 0);
  endtask

  initial begin
    for (int j = 0; j < N; j++) wv[j] = '0;
    repeat (3) @(negedge clk);
    slot_tick = 1'b1;  // strobe during reset must not load
    elig = 8'hF0;
    @(negedge clk); #1;
    t_reset();
    slot_tick = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    t_distinct();
    t_single();
    t_ties();
    t_none();
    t_masked();
    t_grant();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule